// File: doc/BRIEF.md
# Error-tagged UART receive FIFO

This block is the receive-side character store of one serial channel. A receiver front end presents one character per strobe together with its parity, framing, break and overrun indications. Each accepted character is kept with its four flags in a 512-entry first-in-first-out store, so software always sees a character next to the errors that came with it. Incoming characters are only taken while the receive enable is high.

Software reads the oldest entry through a 12-bit data word, observes how many characters are held through a 16-bit occupancy value, and empties the store with a level-sensitive flush that it holds for a short time and then releases. A 2-bit trigger code picks the occupancy at which a receive-data-available level is raised, so interrupt traffic can be traded against latency.

The store never overwrites. A character that arrives while all 512 entries are taken is dropped, and the loss is reported on the next character that does get stored.

Top module: `rx_err_fifo`

## Requirements
- R1: The store holds up to 512 characters, and `count` always equals the number of characters held (0 to 512).
- R2: `rd_data` presents the oldest held entry with the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. A pulse on `rd_en` removes that entry, and entries come out in arrival order.
- R3: While the store is empty, `rd_data` reads as zero, and a read pulse leaves `count` at zero.
- R4: While `rx_en` is low, a strobe on `wr_valid` is ignored and `count` does not change.
- R5: The trigger code on `trig_sel` selects the threshold. Code 1 selects 1 entry, code 2 selects 256 entries, code 3 selects 448 entries, and code 0 keeps `rx_avail` low.
- R6: `rx_avail` is a level. It is high exactly while `rx_irq_en` is high, the code is nonzero and `count` is at or above the selected threshold.
- R7: A write that arrives while 512 entries are held is dropped and `count` stays at 512. The next character that is stored has its overrun bit (bit 9) set, whether or not the front end flagged it.
- R8: While `flush` is high, the store is empty (`count` is 0 and `rd_data` is 0), and writes and reads are ignored. A pending overrun report is discarded. Normal operation resumes after release.
- R9: A write and a read in the same cycle, with the store neither empty nor full, both take effect and leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; characters are accepted only while high |
| wr_valid | input | 1 | Front end presents a character this cycle |
| wr_char | input | 8 | Received character |
| wr_parity | input | 1 | Parity error for this character |
| wr_overrun | input | 1 | Overrun reported by the front end |
| wr_framing | input | 1 | Framing error for this character |
| wr_break | input | 1 | Break condition for this character |
| rd_en | input | 1 | Read strobe; removes the oldest entry |
| rd_data | output | 12 | Oldest entry with its flags, zero when empty |
| count | output | 16 | Number of characters held |
| trig_sel | input | 2 | Trigger code: 0 off, 1 one entry, 2 256 entries, 3 448 entries |
| rx_irq_en | input | 1 | Receive indication enable |
| flush | input | 1 | Level flush; empties the store while high |
| rx_avail | output | 1 | Receive-data-available level |

## Verification
Several properties are checked on every cycle:
- `count` never exceeds 512, and the data word is zero whenever the store is empty.
- One cycle after flush, the store is empty.
- With reception disabled and no read, the count holds, and a full store stays full under further writes.
- A combined read and write leaves the count in place.
- The available level never rises with the enable off, with trigger code 0, or with an empty store.

Some behaviour can only be shown by the bench's scenarios:
- Arrival order and the flag bit positions.
- The exact thresholds of 1, 256 and 448 entries.
- The late overrun mark on the character after a drop.
- That flush discards a pending overrun report.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int CHAR_W = 8;

    // Entry layout, MSB first: break, framing, overrun, parity, character
    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              ovr;
        logic              par;
        logic [CHAR_W-1:0] ch;
    } rx_word_t;

    localparam int WORD_W = $bits(rx_word_t);

    typedef struct packed {
        logic ovr_pend;
    } ovr_st_t;
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
    parameter  int DEPTH = 512,
    parameter  int W     = 12,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] lvl;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.lvl = '0;
        end else begin
            if (push) s_d.wp = bump(s_q.wp);
            if (pop)  s_d.rp = bump(s_q.rp);
            case ({push, pop})
                2'b10:   s_d.lvl = s_q.lvl + 1'b1;
                2'b01:   s_d.lvl = s_q.lvl - 1'b1;
                default: s_d.lvl = s_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[s_q.wp] <= wdata;
    end

    assign rdata = (s_q.lvl == '0) ? '0 : mem[s_q.rp];
    assign level = s_q.lvl;
endmodule

// File: rtl/rxf_trig.sv
`timescale 1ns/1ps
module rxf_trig #(
    parameter int CW  = 10,
    parameter int TH1 = 1,
    parameter int TH2 = 256,
    parameter int TH3 = 448
) (
    input  logic [1:0]    sel,
    input  logic          en,
    input  logic [CW-1:0] level,
    output logic          avail
);
    logic [3:0] hit;

    assign hit[0] = 1'b0;

    genvar g;
    generate
        for (g = 1; g < 4; g++) begin : g_cmp
            localparam int T = (g == 1) ? TH1 : (g == 2) ? TH2 : TH3;
            assign hit[g] = (level >= CW'(T));
        end
    endgenerate

    assign avail = en & hit[sel];
endmodule

// File: rtl/rx_err_fifo.sv
`timescale 1ns/1ps
module rx_err_fifo #(
    parameter int DEPTH    = 512,
    parameter int CNT_W    = 16,
    parameter int TRIG_LO  = 1,
    parameter int TRIG_MID = 256,
    parameter int TRIG_HI  = 448
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en,
    input  logic                       wr_valid,
    input  logic [rxf_pkg::CHAR_W-1:0] wr_char,
    input  logic                       wr_parity,
    input  logic                       wr_overrun,
    input  logic                       wr_framing,
    input  logic                       wr_break,
    input  logic                       rd_en,
    output logic [rxf_pkg::WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]           count,
    input  logic [1:0]                 trig_sel,
    input  logic                       rx_irq_en,
    input  logic                       flush,
    output logic                       rx_avail
);
    import rxf_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    ovr_st_t        st_d, st_q;
    logic [CW-1:0]  level;
    logic           full, empty, accept, push, pop, drop;
    rx_word_t       entry;

    assign full   = (level == CW'(DEPTH));
    assign empty  = (level == '0);
    assign accept = wr_valid & rx_en & ~flush;
    assign push   = accept & ~full;
    assign drop   = accept & full;
    assign pop    = rd_en & ~empty & ~flush;

    always_comb begin
        entry.ch  = wr_char;
        entry.par = wr_parity;
        entry.ovr = wr_overrun | st_q.ovr_pend;
        entry.frm = wr_framing;
        entry.brk = wr_break;
    end

    always_comb begin
        st_d = st_q;
        if (flush)     st_d.ovr_pend = 1'b0;
        else if (push) st_d.ovr_pend = 1'b0;
        else if (drop) st_d.ovr_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxf_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush),
        .push  (push),
        .pop   (pop),
        .wdata (entry),
        .rdata (rd_data),
        .level (level)
    );

    rxf_trig #(.CW(CW), .TH1(TRIG_LO), .TH2(TRIG_MID), .TH3(TRIG_HI)) u_trig (
        .sel   (trig_sel),
        .en    (rx_irq_en),
        .level (level),
        .avail (rx_avail)
    );

    generate
        if (CNT_W > CW) begin : g_pad
            assign count = {{(CNT_W - CW){1'b0}}, level};
        end else begin : g_fit
            assign count = level[CNT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rxf_chk.sv
`timescale 1ns/1ps
module rxf_chk #(
    parameter int DEPTH = 512,
    parameter int CNT_W = 16,
    parameter int WW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             wr_valid,
    input logic             rd_en,
    input logic             flush,
    input logic             rx_irq_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] count,
    input logic [WW-1:0]    rd_data,
    input logic             rx_avail
);
    // R1
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rd_data == '0));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R4
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_en && !flush) |=> $stable(count));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !rd_en && !flush) |=> (count == CNT_W'(DEPTH)));

    // R9
    rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_valid && rx_en && !flush && count != '0 && count != CNT_W'(DEPTH))
        |=> $stable(count));

    // R6
    avail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |-> (rx_irq_en && count != '0));

    // R5
    trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'd0) |-> !rx_avail);
endmodule

bind rx_err_fifo rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .WW(rxf_pkg::WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .wr_valid  (wr_valid),
    .rd_en     (rd_en),
    .flush     (flush),
    .rx_irq_en (rx_irq_en),
    .trig_sel  (trig_sel),
    .count     (count),
    .rd_data   (rd_data),
    .rx_avail  (rx_avail)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, wr_valid = 1'b0;
    logic [7:0]  wr_char = '0;
    logic        wr_parity = 1'b0, wr_overrun = 1'b0, wr_framing = 1'b0, wr_break = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic [15:0] count;
    logic [1:0]  trig_sel = 2'd0;
    logic        rx_irq_en = 1'b0, flush = 1'b0, rx_avail;

    int checks = 0, errors = 0;
    logic [11:0] sb [$];
    bit pend = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_err_fifo u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
        .wr_char(wr_char), .wr_parity(wr_parity), .wr_overrun(wr_overrun),
        .wr_framing(wr_framing), .wr_break(wr_break), .rd_en(rd_en),
        .rd_data(rd_data), .count(count), .trig_sel(trig_sel),
        .rx_irq_en(rx_irq_en), .flush(flush), .rx_avail(rx_avail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: flags = {brk, frm, ovr, par}
    task automatic push_char(input logic [7:0] c, input logic [3:0] f);
        @(negedge clk);
        wr_valid = 1'b1; wr_char = c;
        wr_break = f[3]; wr_framing = f[2]; wr_overrun = f[1]; wr_parity = f[0];
        @(posedge clk);
        if (rx_en && !flush) begin
            if (sb.size() < DEPTH) begin
                sb.push_back({f[3], f[2], f[1] | pend, f[0], c});
                pend = 1'b0;
            end else begin
                pend = 1'b1;
            end
        end
        #1 wr_valid = 1'b0;
    endtask

    // monitor side: compare the presented word with the scoreboard head, then pop
    task automatic read_chk(input string req);
        logic [11:0] exp;
        @(negedge clk);
        exp = (sb.size() != 0) ? sb[0] : 12'h000;
        check(req, {20'h0, rd_data}, {20'h0, exp});
        rd_en = 1'b1;
        @(posedge clk);
        if (sb.size() != 0 && !flush) void'(sb.pop_front());
        #1 rd_en = 1'b0;
    endtask

    task automatic rw_char(input logic [7:0] c);
        logic [11:0] exp;
        @(negedge clk);
        exp = sb[0];
        check("R9 data", {20'h0, rd_data}, {20'h0, exp});
        wr_valid = 1'b1; wr_char = c;
        wr_break = 0; wr_framing = 0; wr_overrun = 0; wr_parity = 0;
        rd_en = 1'b1;
        @(posedge clk);
        void'(sb.pop_front());
        sb.push_back({4'b0000, c});
        #1 wr_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        while (sb.size() != 0) read_chk(req);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rx_en = 1'b1;
        #1;
        check("R1 reset count", {16'h0, count}, 0);
        check("R3 reset data", {20'h0, rd_data}, 0);
        check("R6 reset avail", {31'h0, rx_avail}, 0);

        // R2 flag positions and order
        push_char(8'hA5, 4'b0001);
        push_char(8'h3C, 4'b0100);
        push_char(8'h7E, 4'b1000);
        push_char(8'h11, 4'b0010);
        check("R1 count 4", {16'h0, count}, 4);
        drain("R2 fifo order");
        check("R1 count 0", {16'h0, count}, 0);

        // R3 empty read
        read_chk("R3 empty read");
        #1 check("R3 count stays 0", {16'h0, count}, 0);

        // R4 disabled receive
        rx_en = 1'b0;
        push_char(8'h55, 4'b0000);
        check("R4 ignored write", {16'h0, count}, 0);
        rx_en = 1'b1;

        // R5/R6 trigger code 1
        trig_sel = 2'd1; rx_irq_en = 1'b1; #1;
        check("R6 empty no avail", {31'h0, rx_avail}, 0);
        push_char(8'h01, 4'b0000);
        check("R5 code1 avail", {31'h0, rx_avail}, 1);
        rx_irq_en = 1'b0; #1;
        check("R6 irq disabled", {31'h0, rx_avail}, 0);
        rx_irq_en = 1'b1; trig_sel = 2'd0; #1;
        check("R5 code0 off", {31'h0, rx_avail}, 0);

        // R9 simultaneous read and write
        push_char(8'h02, 4'b0000);
        rw_char(8'h03);
        #1 check("R9 count held", {16'h0, count}, 2);
        drain("R9 order");

        // R5 thresholds 256 and 448
        trig_sel = 2'd2;
        for (int i = 0; i < 255; i++) push_char(i[7:0], 4'b0000);
        check("R5 255 below 256", {31'h0, rx_avail}, 0);
        push_char(8'hFF, 4'b0000);
        check("R5 at 256", {31'h0, rx_avail}, 1);
        trig_sel = 2'd3; #1;
        check("R5 256 below 448", {31'h0, rx_avail}, 0);
        for (int i = 256; i < 447; i++) push_char(i[7:0], 4'b0000);
        check("R5 447 below 448", {31'h0, rx_avail}, 0);
        push_char(8'hC0, 4'b0000);
        check("R5 at 448", {31'h0, rx_avail}, 1);

        // R7 full, drop, late overrun mark
        for (int i = 448; i < DEPTH; i++) push_char(i[7:0], 4'b0000);
        check("R1 full count", {16'h0, count}, DEPTH);
        push_char(8'hEE, 4'b0000);
        check("R7 drop keeps count", {16'h0, count}, DEPTH);
        read_chk("R7 read after drop");
        push_char(8'h77, 4'b0000);
        check("R7 refill count", {16'h0, count}, DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) read_chk("R7 drain");
        check("R7 overrun bit", {31'h0, rd_data[9]}, 1);
        check("R7 late char", {24'h0, rd_data[7:0]}, 8'h77);
        drain("R7 last");

        // R8 flush discards content and pending overrun
        for (int i = 0; i < DEPTH; i++) push_char(i[7:0], 4'b0000);
        push_char(8'hDD, 4'b0000);
        @(negedge clk); flush = 1'b1;
        sb.delete(); pend = 1'b0;
        push_char(8'h44, 4'b0000);
        check("R8 count during flush", {16'h0, count}, 0);
        check("R8 data during flush", {20'h0, rd_data}, 0);
        @(negedge clk); flush = 1'b0;
        #1 check("R8 count after flush", {16'h0, count}, 0);
        push_char(8'h66, 4'b0000);
        check("R8 resume count", {16'h0, count}, 1);
        check("R8 pending cleared", {31'h0, rd_data[9]}, 0);
        drain("R8 resume data");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule